// File: doc/BRIEF.md
# Oversampling Serial Byte Receiver with Spike Filter

This block takes an asynchronous serial line and turns it into bytes. A frame is a low start bit, then the data bits with the least significant bit first, then a high stop bit. There is no parity bit. The block does not make its own sampling rate. A strobe from outside, one system clock wide and running at eight times the bit rate, sets the rate. All internal state moves only on clocks where that strobe is high.

The line first passes through a chain of synchronizing flops that sample on the strobe. A small saturating up/down counter then cleans the line. The filtered level flips only when the counter hits one of its rails, so a brief spike does not look like a start bit. A low filtered level while idle starts a frame. A three-bit spacing counter then marks one bit boundary every eight strobes. At each boundary in the data phase, the filtered level enters the top of a shift register. At the stop boundary a one-clock ready pulse appears, but only if the line is high there. The byte output is meaningful only while that pulse is high.

Top module: `uart_rx_os8`

## Requirements
- R1: The synchronizer, filter counter, filtered level, frame state and shift register change only on clocks where `os_tick` is high.
- R2: The filter counter moves by at most one step per strobe. It counts up toward 3 while the synchronized line is high and down toward 0 while it is low, and it stops at both ends.
- R3: The filtered level goes low only after the counter has reached 0 and high only after it has reached 3. A low pulse on an idle line that lasts one or two strobe samples is therefore ignored. A low pulse that lasts three samples starts a frame.
- R4: In idle, a low filtered level moves the receiver straight into the data phase. The receiver leaves idle for no other reason.
- R5: The bit spacing counter is zero in idle and steps by one on each strobe outside idle. A bit boundary falls on the strobe where it reads 7.
- R6: The byte is assembled with the least significant bit first. The first data bit received appears on `rx_data[0]` and the last on `rx_data[7]`.
- R7: `rx_ready` is a pulse one system clock wide. It is issued at the stop boundary, after which the receiver is back in idle.
- R8: If the stop bit reads low, the frame gives no `rx_ready` pulse.
- R9: After reset, `rx_ready` is 0 and `rx_data` is 0x00.
- R10: Every byte is received correctly, including frames sent back to back, when the sender's bit time is between 95.5% and 100% of eight strobe periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| os_tick | input | 1 | Sampling strobe at eight times the bit rate, one clock wide |
| rxd | input | 1 | Asynchronous serial line, idle high |
| rx_data | output | 8 | Received byte, meaningful while rx_ready is high |
| rx_ready | output | 1 | One-clock pulse when a frame with a high stop bit completes |

## Verification
The hardest case to reach from the ports is the filter threshold: the counter has to be pushed exactly one, two or three steps off its upper rail without any extra samples. The strobe comes from a bench divider with a period of 24 clocks, so the bench holds the line low for exactly 24, 48 or 72 clocks. Each window then contains exactly that many sampling strobes. The first two must give no pulse at all. The third must produce a frame made entirely of ones. The second hard case is bit-time drift, since the sample point sits early in each bit. The bench sends frames, some of them back to back, with bit times of 184, 188 and 191 clocks against the receiver's 192.

// File: rtl/uart_rx_pkg.sv
// Types shared by the serial byte receiver.
// Assumes nothing beyond synthesizable enumerations.
package uart_rx_pkg;
    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_DATA = 2'd1,
        RX_STOP = 2'd2
    } rx_state_e;
endpackage

// File: rtl/uart_rx_line_filter.sv
// Synchronizes the raw serial line on the sampling strobe, then applies a
// saturating up/down counter with hysteresis to give a spike-free level.
// Assumes: tick is one clock wide; SYNC_STAGES >= 2; the line idles high.
module uart_rx_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic line_in,
    output logic line_filt
);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] CNT_MIN  = '0;
    localparam logic [CNT_W-1:0] CNT_STEP = CNT_W'(1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CNT_W-1:0]       lvl_cnt;
    logic                   line_sync;

    assign line_sync = sync_q[SYNC_STAGES-1];

    // Purpose: shift the raw line through the synchronizer chain on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sync_q <= '1;
        else if (tick)
            sync_q <= {sync_q[SYNC_STAGES-2:0], line_in};
    end

    // Purpose: saturating count toward the synchronized line level.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lvl_cnt <= CNT_MAX;
        else if (tick) begin
            if (line_sync && lvl_cnt != CNT_MAX)
                lvl_cnt <= lvl_cnt + CNT_STEP;
            else if (!line_sync && lvl_cnt != CNT_MIN)
                lvl_cnt <= lvl_cnt - CNT_STEP;
        end
    end

    // Purpose: flip the filtered level only when the counter rests on a rail.
    always_ff @(posedge clk) begin
        if (!rst_n)
            line_filt <= 1'b1;
        else if (tick) begin
            if (lvl_cnt == CNT_MIN)
                line_filt <= 1'b0;
            else if (lvl_cnt == CNT_MAX)
                line_filt <= 1'b1;
        end
    end

    // R1
    filt_tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tick) |-> ($stable(sync_q) && $stable(lvl_cnt) && $stable(line_filt)));

    // R2
    cnt_single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lvl_cnt) |-> (lvl_cnt == $past(lvl_cnt) + CNT_STEP ||
                               lvl_cnt == $past(lvl_cnt) - CNT_STEP));

    // R3
    filt_rail_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(line_filt) |-> ($past(lvl_cnt) == CNT_MIN || $past(lvl_cnt) == CNT_MAX));
endmodule

// File: rtl/uart_rx_bit_timer.sv
// Bit spacing counter: held at zero while the receiver is idle, and otherwise
// steps on every strobe. It flags a boundary once per OVERSAMPLE strobes.
// Assumes: run comes from the frame FSM; tick is one clock wide.
module uart_rx_bit_timer #(
    parameter int OVERSAMPLE = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic run,
    output logic boundary
);
    localparam int            SP_W    = $clog2(OVERSAMPLE);
    localparam logic [SP_W-1:0] SP_LAST = SP_W'(OVERSAMPLE - 1);
    localparam logic [SP_W-1:0] SP_STEP = SP_W'(1);

    logic [SP_W-1:0] spacing;

    // Purpose: count strobes within the current bit; clear while idle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            spacing <= '0;
        else if (!run)
            spacing <= '0;
        else if (tick) begin
            if (spacing == SP_LAST)
                spacing <= '0;
            else
                spacing <= spacing + SP_STEP;
        end
    end

    assign boundary = tick && run && (spacing == SP_LAST);

    // R5
    spacing_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && run && spacing != SP_LAST) |=> (spacing == $past(spacing) + SP_STEP));
endmodule

// File: rtl/uart_rx_frame_fsm.sv
// Frame sequencer: detects the start from the filtered level, walks through
// the data bits and the stop bit on timer boundaries, shifts the data in
// least significant bit first, and pulses ready when the stop bit reads high.
// Assumes: line_filt is already synchronized and filtered; boundary implies tick.
module uart_rx_frame_fsm
    import uart_rx_pkg::*;
#(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 line_filt,
    input  logic                 boundary,
    output logic                 run,
    output logic [DATA_BITS-1:0] data_out,
    output logic                 ready
);
    localparam int               IDX_W    = $clog2(DATA_BITS);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_BITS - 1);
    localparam logic [IDX_W-1:0] IDX_STEP = IDX_W'(1);

    rx_state_e       state;
    logic [IDX_W-1:0] bit_idx;

    assign run = (state != RX_IDLE);

    // Purpose: advance the frame state on strobes and bit boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= RX_IDLE;
            bit_idx <= '0;
        end else if (tick) begin
            case (state)
                RX_IDLE: begin
                    bit_idx <= '0;
                    if (!line_filt)
                        state <= RX_DATA;
                end
                RX_DATA: if (boundary) begin
                    if (bit_idx == IDX_LAST)
                        state <= RX_STOP;
                    else
                        bit_idx <= bit_idx + IDX_STEP;
                end
                RX_STOP: if (boundary)
                    state <= RX_IDLE;
                default: state <= RX_IDLE;
            endcase
        end
    end

    // Purpose: shift each data bit into the top so the first lands in bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n)
            data_out <= '0;
        else if (boundary && state == RX_DATA)
            data_out <= {line_filt, data_out[DATA_BITS-1:1]};
    end

    // Purpose: one-clock ready when the stop bit reads high.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ready <= 1'b0;
        else
            ready <= boundary && (state == RX_STOP) && line_filt;
    end

    // R1
    fsm_tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tick) |-> ($stable(state) && $stable(data_out)));

    // R4
    idle_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == RX_IDLE && state != RX_IDLE) |-> (state == RX_DATA && !$past(line_filt)));

    // R7
    ready_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);

    // R7
    ready_at_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> ($past(state) == RX_STOP && state == RX_IDLE));

    // R8
    low_stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> $past(line_filt));
endmodule

// File: rtl/uart_rx_os8.sv
// Top of the oversampling serial byte receiver: line filter, bit timer and
// frame sequencer in a chain. Assumes os_tick runs at OVERSAMPLE times the
// bit rate and is one clock wide; the frame has no parity and one stop bit.
module uart_rx_os8 #(
    parameter int DATA_BITS   = 8,
    parameter int OVERSAMPLE  = 8,
    parameter int SYNC_STAGES = 2,
    parameter int FILT_W      = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 os_tick,
    input  logic                 rxd,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_ready
);
    logic line_filt;
    logic boundary;
    logic run;

    uart_rx_line_filter #(
        .SYNC_STAGES (SYNC_STAGES),
        .CNT_W       (FILT_W)
    ) u_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (os_tick),
        .line_in   (rxd),
        .line_filt (line_filt)
    );

    uart_rx_bit_timer #(
        .OVERSAMPLE (OVERSAMPLE)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (os_tick),
        .run      (run),
        .boundary (boundary)
    );

    uart_rx_frame_fsm #(
        .DATA_BITS (DATA_BITS)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (os_tick),
        .line_filt (line_filt),
        .boundary  (boundary),
        .run       (run),
        .data_out  (rx_data),
        .ready     (rx_ready)
    );
endmodule

// File: tb/sim_uart_rx_os8.sv
module sim_uart_rx_os8;
    localparam int TICK_DIV = 24;               // clocks per sampling strobe
    localparam int BIT_RX   = 8 * TICK_DIV;     // receiver bit time, 192 clocks

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic [4:0] tdiv = '0;
    logic       os_tick;
    logic [7:0] rx_data;
    logic       rx_ready;

    int n_checks = 0;
    int n_fail   = 0;
    int n_ready  = 0;
    int n_wide   = 0;
    logic       prev_ready = 1'b0;
    logic [7:0] rx_log [0:63];
    bit         done = 1'b0;

    always #4 clk = ~clk;

    always @(posedge clk) tdiv <= (tdiv == 5'(TICK_DIV - 1)) ? 5'd0 : tdiv + 5'd1;
    assign os_tick = (tdiv == 5'(TICK_DIV - 1));

    uart_rx_os8 u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .os_tick  (os_tick),
        .rxd      (rxd),
        .rx_data  (rx_data),
        .rx_ready (rx_ready)
    );

    // Monitor: log every ready pulse and count pulses wider than one clock.
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_ready) begin
                if (prev_ready) n_wide++;
                else begin
                    rx_log[n_ready % 64] = rx_data;
                    n_ready++;
                end
            end
        end
        prev_ready = rx_ready;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] b, input int bitlen, input logic stop_val);
        rxd = 1'b0;
        wait_clk(bitlen);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            wait_clk(bitlen);
        end
        rxd = stop_val;
        wait_clk(bitlen);
        rxd = 1'b1;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    // R9: outputs while held in reset.
    task automatic t_reset();
        rst_n = 1'b0;
        wait_clk(10);
        check(rx_ready == 1'b0, "R9 ready in reset", rx_ready, 0);
        check(rx_data == 8'h00, "R9 data in reset", rx_data, 0);
        rst_n = 1'b1;
        wait_clk(2 * BIT_RX);
        check(n_ready == 0, "R9 no pulse on idle line", n_ready, 0);
    endtask

    // R6/R10: single frames at a given bit time, checked one by one.
    task automatic t_bytes(input int bitlen, input string tag);
        logic [7:0] pat [0:7] = '{8'h55, 8'hC4, 8'h00, 8'hFF, 8'h80, 8'h01, 8'hA5, 8'h3C};
        for (int i = 0; i < 8; i++) begin
            int base = n_ready;
            send_frame(pat[i], bitlen, 1'b1);
            wait_clk(BIT_RX);
            check(n_ready == base + 1, {tag, " R7 one pulse per frame"}, n_ready - base, 1);
            check(rx_log[base % 64] == pat[i], {tag, " R6 byte LSB first"}, rx_log[base % 64], pat[i]);
        end
    endtask

    // R10: back-to-back frames with no idle gap.
    task automatic t_back_to_back(input int bitlen);
        logic [7:0] pat [0:5] = '{8'h12, 8'hFE, 8'h7F, 8'h00, 8'hB6, 8'h49};
        int base = n_ready;
        for (int i = 0; i < 6; i++) send_frame(pat[i], bitlen, 1'b1);
        wait_clk(2 * BIT_RX);
        check(n_ready == base + 6, "R10 back-to-back count", n_ready - base, 6);
        for (int i = 0; i < 6; i++)
            check(rx_log[(base + i) % 64] == pat[i], "R10 back-to-back byte",
                  rx_log[(base + i) % 64], pat[i]);
    endtask

    // R3: idle-line spikes of one, two and three strobe samples.
    task automatic t_glitch();
        int base = n_ready;
        rxd = 1'b0; wait_clk(TICK_DIV); rxd = 1'b1;
        wait_clk(12 * BIT_RX);
        check(n_ready == base, "R3 one-sample spike ignored", n_ready - base, 0);
        rxd = 1'b0; wait_clk(2 * TICK_DIV); rxd = 1'b1;
        wait_clk(12 * BIT_RX);
        check(n_ready == base, "R3 two-sample spike ignored", n_ready - base, 0);
        rxd = 1'b0; wait_clk(3 * TICK_DIV); rxd = 1'b1;
        wait_clk(12 * BIT_RX);
        check(n_ready == base + 1, "R3 three-sample low starts frame", n_ready - base, 1);
        check(rx_log[base % 64] == 8'hFF, "R4 frame after start holds ones", rx_log[base % 64], 8'hFF);
        base = n_ready;
        send_frame(8'h96, 188, 1'b1);
        wait_clk(BIT_RX);
        check(n_ready == base + 1 && rx_log[base % 64] == 8'h96, "R6 byte after spikes",
              rx_log[base % 64], 8'h96);
    endtask

    // R8: a low stop bit gives no pulse; the receiver then recovers.
    task automatic t_low_stop();
        int base = n_ready;
        send_frame(8'h5A, 188, 1'b0);
        wait_clk(100);
        check(n_ready == base, "R8 no pulse on low stop", n_ready - base, 0);
        wait_clk(14 * BIT_RX);
        base = n_ready;
        send_frame(8'hC3, 188, 1'b1);
        wait_clk(BIT_RX);
        check(n_ready == base + 1 && rx_log[base % 64] == 8'hC3, "R8 recovery byte",
              rx_log[base % 64], 8'hC3);
    endtask

    initial begin
        t_reset();
        t_bytes(188, "nominal");
        t_bytes(184, "fast");
        t_bytes(191, "slow");
        t_back_to_back(191);
        t_back_to_back(184);
        t_glitch();
        t_low_stop();
        check(n_wide == 0, "R7 ready one clock wide", n_wide, 0);
        done = 1'b1;
        finish_run();
    end

    initial begin
        wait_clk(190000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            finish_run();
        end
    end
endmodule